// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control section of a 128-tap digitally controlled potentiometer. A host drives three slow pins: an active-low select, an active-low step strobe and a direction level. All three pass through two-flop synchronizers into the system clock domain, where their edges are detected. While the block is selected, each falling edge of the step strobe moves a 7-bit wiper code one position up or down. The code saturates at both ends. The code is decoded to a one-hot 128-bit tap select.

Releasing the select pin is a commit decision. If the step strobe is high at that moment, the code is written into a modelled nonvolatile register. A timed busy period follows, and the block then returns to standby. If the step strobe is low, the block returns to standby at once and nothing is written. A power-up reset starts a timed recall that loads the nonvolatile value into the wiper code. The nonvolatile register has its own clear input, which models an unprogrammed part; a power-up reset leaves that register untouched.

Top module: `updown_wiper_ctrl`

## Requirements
- R1: After `rst_n` is released, `busy` stays high for exactly RECALL_CYCLES clock cycles. `wiper_code` then equals the nonvolatile value, which is NV_DEFAULT after `nv_clear_n` has been asserted.
- R2: While `sel_n` is high, edges on `step_n` and levels on `dir_up` leave `wiper_code` unchanged.
- R3: While selected and not busy, each falling edge of `step_n` moves `wiper_code` by one: up when `dir_up` is 1, down when it is 0. The new code is visible three clock edges after the pin changes.
- R4: A step down at code 0 and a step up at code 127 leave the code unchanged. The code never wraps.
- R5: `tap_sel` has exactly one bit set, and that bit is the one indexed by `wiper_code`.
- R6: A rising edge of `sel_n` while `step_n` is high writes the code into the nonvolatile register. `busy` is then high for exactly STORE_CYCLES cycles, after which `standby` is high. The next power-up recall returns the written code.
- R7: A rising edge of `sel_n` while `step_n` is low raises `standby` with no busy period and keeps the code. The nonvolatile value is unchanged, so the next recall returns the previous stored code.
- R8: While `busy` is high, falling edges of `step_n` are ignored. If `sel_n` is low when `busy` clears, the block becomes selected afterwards (`standby` low).
- R9: `dir_up` may change between steps within one selection, and each step follows the direction level present at its edge.
- R10: If the select release and a step falling edge reach the synchronized domain in the same cycle, the release wins. The code does not move, and because the step level is low no store takes place.
- R11: `busy` and `standby` are never high together. `standby` is high exactly when the block is deselected and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset; starts a recall |
| nv_clear_n | input | 1 | Asynchronous active-low clear of the nonvolatile register to NV_DEFAULT |
| sel_n | input | 1 | Asynchronous active-low device select |
| step_n | input | 1 | Asynchronous step strobe; its falling edge moves the wiper |
| dir_up | input | 1 | Direction level: 1 moves up, 0 moves down |
| wiper_code | output | 7 | Current wiper position code |
| tap_sel | output | 128 | One-hot tap select decoded from the code |
| busy | output | 1 | High during a store or a power-up recall |
| standby | output | 1 | High while deselected and idle |

## Verification
The select release and a step falling edge can land in the same synchronized cycle. In that cycle one event asks for a move and the other asks for a commit that depends on the step level. The bench provokes this by changing `sel_n` and `step_n` in the same instant. It then expects an unchanged code, no busy period, and no change to the value seen at the following recall. A second overlap is a step edge arriving while a store is still busy. The bench judges it by checking that the code is unchanged once `busy` falls.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef enum logic [1:0] {
    WS_RECALL  = 2'd0,
    WS_STANDBY = 2'd1,
    WS_ACTIVE  = 2'd2,
    WS_STORE   = 2'd3
  } wiper_state_e;

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/wiper_counter.sv
module wiper_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic         up,
  output logic [W-1:0] code_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] code_q;
  logic [W-1:0] code_d;
  logic         code_en;

  always_comb begin
    code_d  = code_q;
    code_en = 1'b0;
    if (load_en) begin
      code_d  = load_val;
      code_en = 1'b1;
    end else if (step_en) begin
      if (up && (code_q != TOP)) begin
        code_d  = code_q + 1'b1;
        code_en = 1'b1;
      end else if (!up && (code_q != '0)) begin
        code_d  = code_q - 1'b1;
        code_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/wiper_nvcell.sv
module wiper_nvcell #(
  parameter int           W             = 7,
  parameter int           STORE_CYCLES  = 4000000,
  parameter int           RECALL_CYCLES = 600000,
  parameter logic [W-1:0] NV_DEFAULT    = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         nv_clear_n,
  input  logic         store_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] data_o,
  output logic         busy_o,
  output logic         done_o
);

  localparam int LONGEST = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CW      = (LONGEST > 2) ? $clog2(LONGEST) : 1;
  localparam logic [CW-1:0] STORE_LD  = CW'(STORE_CYCLES - 1);
  localparam logic [CW-1:0] RECALL_LD = CW'(RECALL_CYCLES - 1);

  logic [W-1:0]  mem_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          busy_q;
  logic          busy_d;
  logic          done;

  // Nonvolatile content: survives rst_n, cleared only by nv_clear_n.
  always_ff @(posedge clk or negedge nv_clear_n) begin
    if (!nv_clear_n) begin
      mem_q <= NV_DEFAULT;
    end else if (store_i) begin
      mem_q <= data_i;
    end
  end

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (store_i) begin
      cnt_d  = STORE_LD;
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  // Reset value arms the power-up recall interval.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RECALL_LD;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign data_o = mem_q;
  assign busy_o = busy_q;
  assign done_o = done;

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int W    = 7,
  parameter int TAPS = 1 << W
) (
  input  logic [W-1:0]    code_i,
  output logic [TAPS-1:0] tap_o
);

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    assign tap_o[g] = (code_i == W'(g));
  end

endmodule

// File: rtl/updown_wiper_ctrl.sv
module updown_wiper_ctrl
  import wiper_pkg::*;
#(
  parameter int                CODE_W        = 7,
  parameter int                STORE_CYCLES  = 4000000,
  parameter int                RECALL_CYCLES = 600000,
  parameter logic [CODE_W-1:0] NV_DEFAULT    = 7'h40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     nv_clear_n,
  input  logic                     sel_n,
  input  logic                     step_n,
  input  logic                     dir_up,
  output logic [CODE_W-1:0]        wiper_code,
  output logic [(1<<CODE_W)-1:0]   tap_sel,
  output logic                     busy,
  output logic                     standby
);

  localparam int TAPS   = 1 << CODE_W;
  localparam int NPINS  = 3;
  localparam int P_SEL  = 0;
  localparam int P_STEP = 1;
  localparam int P_DIR  = 2;

  logic [NPINS-1:0]  pins_raw;
  logic [NPINS-1:0]  pins_s;
  logic              sel_s;
  logic              step_s;
  logic              dir_s;
  logic              sel_prev_q;
  logic              step_prev_q;
  logic              sel_rise;
  logic              step_fall;

  wiper_state_e      state_q;
  wiper_state_e      state_d;
  logic              store_go;
  logic              move_en;
  logic              load_en;
  logic              nv_busy;
  logic              nv_done;
  logic [CODE_W-1:0] nv_value;

  assign pins_raw = {dir_up, step_n, sel_n};

  wiper_sync #(.W(NPINS), .RST_VAL({NPINS{1'b1}})) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_raw),
    .sync_o  (pins_s)
  );

  assign sel_s  = pins_s[P_SEL];
  assign step_s = pins_s[P_STEP];
  assign dir_s  = pins_s[P_DIR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev_q  <= 1'b1;
      step_prev_q <= 1'b1;
    end else begin
      sel_prev_q  <= sel_s;
      step_prev_q <= step_s;
    end
  end

  assign sel_rise  = sel_s & ~sel_prev_q;
  assign step_fall = ~step_s & step_prev_q;

  // Release takes precedence over a coincident step edge.
  always_comb begin
    state_d  = state_q;
    store_go = 1'b0;
    move_en  = 1'b0;
    load_en  = 1'b0;
    unique case (state_q)
      WS_RECALL: begin
        if (nv_done) begin
          load_en = 1'b1;
          state_d = WS_STANDBY;
        end
      end
      WS_STANDBY: begin
        if (!sel_s) state_d = WS_ACTIVE;
      end
      WS_ACTIVE: begin
        if (sel_rise) begin
          if (step_s) begin
            store_go = 1'b1;
            state_d  = WS_STORE;
          end else begin
            state_d  = WS_STANDBY;
          end
        end else if (step_fall) begin
          move_en = 1'b1;
        end
      end
      WS_STORE: begin
        if (nv_done) state_d = WS_STANDBY;
      end
      default: state_d = WS_RECALL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_RECALL;
    end else begin
      state_q <= state_d;
    end
  end

  wiper_nvcell #(
    .W             (CODE_W),
    .STORE_CYCLES  (STORE_CYCLES),
    .RECALL_CYCLES (RECALL_CYCLES),
    .NV_DEFAULT    (NV_DEFAULT)
  ) u_nv (
    .clk        (clk),
    .rst_n      (rst_n),
    .nv_clear_n (nv_clear_n),
    .store_i    (store_go),
    .data_i     (wiper_code),
    .data_o     (nv_value),
    .busy_o     (nv_busy),
    .done_o     (nv_done)
  );

  wiper_counter #(.W(CODE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (load_en),
    .load_val (nv_value),
    .step_en  (move_en),
    .up       (dir_s),
    .code_o   (wiper_code)
  );

  wiper_tap_decode #(.W(CODE_W), .TAPS(TAPS)) u_dec (
    .code_i (wiper_code),
    .tap_o  (tap_sel)
  );

  assign busy    = nv_busy;
  assign standby = (state_q == WS_STANDBY);

endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int CODE_W = 7,
  parameter int TAPS   = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nv_clear_n,
  input logic              busy,
  input logic              standby,
  input logic [CODE_W-1:0] wiper_code,
  input logic [CODE_W-1:0] nv_value,
  input logic [TAPS-1:0]   tap_sel
);

  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1) else $error("one tap"); // R5

  AST_TAP_AT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel[wiper_code]) else $error("tap index"); // R5

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> (({1'b0, wiper_code} == {1'b0, $past(wiper_code)}) ||
                      ({1'b0, wiper_code} == {1'b0, $past(wiper_code)} + 1'b1) ||
                      ({1'b0, wiper_code} + 1'b1 == {1'b0, $past(wiper_code)})))
    else $error("step size"); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> !((($past(wiper_code) == TOP) && (wiper_code == '0)) ||
                       (($past(wiper_code) == '0) && (wiper_code == TOP))))
    else $error("wrap"); // R4

  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wiper_code)) else $error("moved while busy"); // R8

  AST_FROZEN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && $past(standby)) |-> $stable(wiper_code)) else $error("moved in standby"); // R2

  AST_BUSY_STANDBY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && standby)) else $error("busy and standby"); // R11

  AST_NV_ONLY_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n || !nv_clear_n)
    !$stable(nv_value) |-> (busy && !$past(busy))) else $error("nv write"); // R6

endmodule

bind updown_wiper_ctrl wiper_ctrl_chk #(.CODE_W(CODE_W), .TAPS(TAPS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nv_clear_n (nv_clear_n),
  .busy       (busy),
  .standby    (standby),
  .wiper_code (wiper_code),
  .nv_value   (nv_value),
  .tap_sel    (tap_sel)
);

// File: tb/tb_updown_wiper_ctrl.sv
`timescale 1ns/1ps
module tb_updown_wiper_ctrl;

  localparam int         W   = 7;
  localparam int         MAXC = (1 << W) - 1;
  localparam int         STC = 40;
  localparam int         RCC = 30;
  localparam logic [6:0] DEF = 7'h40;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         nv_clear_n;
  logic         sel_n;
  logic         step_n;
  logic         dir_up;
  logic [6:0]   wiper_code;
  logic [127:0] tap_sel;
  logic         busy;
  logic         standby;

  int vectors = 0;
  int fails   = 0;
  int exp_code;
  int stored;

  always #2.5 clk = ~clk;

  updown_wiper_ctrl #(
    .CODE_W(W), .STORE_CYCLES(STC), .RECALL_CYCLES(RCC), .NV_DEFAULT(DEF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .nv_clear_n(nv_clear_n), .sel_n(sel_n),
    .step_n(step_n), .dir_up(dir_up), .wiper_code(wiper_code),
    .tap_sel(tap_sel), .busy(busy), .standby(standby)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_code(input int exp, input string req);
    check(int'(wiper_code) == exp, req, int'(wiper_code), exp);
    check(tap_sel == (128'd1 << exp), "R5 tap one-hot", int'(tap_sel == (128'd1 << exp)), 1);
  endtask

  task automatic step(input bit up);
    dir_up = up;
    tick(3);
    step_n = 1'b0;
    tick(4);
    step_n = 1'b1;
    tick(4);
  endtask

  task automatic model_step(input bit up);
    if (up) exp_code = (exp_code == MAXC) ? MAXC : exp_code + 1;
    else    exp_code = (exp_code == 0) ? 0 : exp_code - 1;
  endtask

  task automatic power_cycle(input int exp);
    int n;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      tick(1);
    end
    check(n == RCC, "R1 recall busy length", n, RCC);
    check_code(exp, "R1 recalled code");
    exp_code = exp;
  endtask

  task automatic select();
    sel_n = 1'b0;
    tick(4);
    check(standby == 1'b0, "R11 standby low when selected", int'(standby), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; nv_clear_n = 1'b0;
    sel_n = 1'b1; step_n = 1'b1; dir_up = 1'b1;
    tick(3);
    check(busy == 1'b1, "R1 busy in reset", int'(busy), 1);
    nv_clear_n = 1'b1;
    tick(1);
    // R1: first power-up recalls NV_DEFAULT
    rst_n = 1'b1;
    n = 0;
    while (busy && n < 1000) begin n++; tick(1); end
    check(n == RCC, "R1 recall busy length", n, RCC);
    check_code(int'(DEF), "R1 default recall");
    check(standby == 1'b1, "R11 standby after recall", int'(standby), 1);
    exp_code = int'(DEF);

    // R2: steps ignored while deselected
    step(1'b1); step(1'b0); step(1'b1);
    check_code(exp_code, "R2 ignored when deselected");

    // R3/R4/R5: sweep up to saturation, then down to saturation
    select();
    for (int i = 0; i < 70; i++) begin
      step(1'b1); model_step(1'b1);
      check_code(exp_code, "R3 R4 up sweep");
    end
    for (int i = 0; i < 132; i++) begin
      step(1'b0); model_step(1'b0);
      check_code(exp_code, "R3 R4 down sweep");
    end

    // R9: direction changes within one selection
    for (int i = 0; i < 12; i++) begin
      bit d = (i % 3) != 2;
      step(d); model_step(d);
      check_code(exp_code, "R9 mixed directions");
    end

    // R7: release with step low: no store
    dir_up = 1'b1; tick(3);
    step_n = 1'b0; tick(4); model_step(1'b1);
    sel_n = 1'b1;
    n = 0;
    for (int i = 0; i < 10; i++) begin tick(1); if (busy) n++; end
    check(n == 0, "R7 no busy on no-store release", n, 0);
    check(standby == 1'b1, "R7 standby after release", int'(standby), 1);
    check_code(exp_code, "R7 code kept");
    step_n = 1'b1; tick(4);
    check_code(exp_code, "R2 rising step ignored deselected");
    power_cycle(int'(DEF));   // R7: nothing was stored

    // R6: store sequence
    select();
    for (int i = 0; i < 5; i++) begin step(1'b1); model_step(1'b1); end
    check_code(exp_code, "R6 pre-store code");
    stored = exp_code;
    sel_n = 1'b1;
    n = 0;
    while (!busy && n < 20) begin n++; tick(1); end
    // R8: select again and step during busy
    sel_n = 1'b0;
    n = 0;
    for (int i = 0; i < 8; i++) begin if (busy) n++; tick(1); end
    step_n = 1'b0;
    for (int i = 0; i < 8; i++) begin if (busy) n++; tick(1); end
    step_n = 1'b1;
    while (busy && n < 1000) begin n++; tick(1); end
    check(n == STC, "R6 store busy length", n, STC);
    tick(3);
    check_code(stored, "R8 step ignored while busy");
    check(standby == 1'b0, "R8 selection accepted after busy", int'(standby), 0);
    sel_n = 1'b1;
    n = 0;
    while (!busy && n < 20) begin n++; tick(1); end
    while (busy && n < 1000) begin n++; tick(1); end
    tick(1);
    check(standby == 1'b1, "R6 standby after store", int'(standby), 1);
    check(busy == 1'b0, "R11 busy clear after store", int'(busy), 0);
    power_cycle(stored);      // R6

    // R10: release and step fall in the same cycle
    select();
    step(1'b0); step(1'b0); model_step(1'b0); model_step(1'b0);
    check_code(exp_code, "R10 pre-collision code");
    dir_up = 1'b1; tick(3);
    sel_n = 1'b1; step_n = 1'b0;
    n = 0;
    for (int i = 0; i < 12; i++) begin tick(1); if (busy) n++; end
    check(n == 0, "R10 no store on collision", n, 0);
    check_code(exp_code, "R10 no move on collision");
    check(standby == 1'b1, "R10 standby after collision", int'(standby), 1);
    step_n = 1'b1; tick(4);
    power_cycle(stored);      // R10: nonvolatile value untouched

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule